// File: doc/BRIEF.md
# Flash command sequencer

This block sits between the external bus of a NOR-style flash model and its program/erase controller. It samples the active-low chip enable, write enable and output enable strobes on the system clock, together with the address and data buses, and recognises multi-cycle write command sequences. Every sequence starts with a two-cycle unlock pair, followed by a set-up code. The sequence then either ends, as for auto select or reset, or continues with further cycles. For program, this is one address/data cycle. For block erase, chip erase, block protect and unprotect, it is a second unlock pair followed by a confirm code.

When a sequence completes, the block raises a single-cycle start pulse for the controller and presents the latched address and data alongside it. It also tracks whether an erase it launched is still running. This lets a single-cycle suspend code pause that erase, so that other blocks can be read or programmed, and a single-cycle resume code restart it. Any unexpected cycle drops the sequencer back to read array mode. A low-supply lockout input forces the same return.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset all start pulses are low, and auto_sel and suspended are 0.
- R2: A bus write cycle lasts while ce_n=0, we_n=0 and oe_n=1. A cycle held with oe_n=0 is not a write and leaves the sequence where it was.
- R3: The address is taken when the write cycle begins, at the later of the ce_n/we_n falls. The data is the last value seen before the cycle ends, at the earlier of the two rises. The cycle acts on the first clock after it ends.
- R4: The unlock pair is data AAh at address 555h, then data 55h at address 2AAh. Only address bits [10:0] are compared, and commands use data bits [7:0].
- R5: Unlock followed by A0h, then one more write, gives a one-cycle go_prog pulse. op_addr and op_data carry that write's address and data.
- R6: Unlock, then 80h, then a second unlock pair, then 30h gives a one-cycle go_berase pulse with op_addr set to the final cycle's address.
- R7: The same six cycles ending in 10h give a one-cycle go_cerase pulse.
- R8: Unlock, then 60h, then a second unlock pair, then 40h gives go_prot with op_addr set to the final address. Ending in 20h instead gives go_unprot.
- R9: Unlock followed by 90h sets auto_sel to 1. The next accepted write cycle clears it.
- R10: A cycle that does not match the expected step returns the sequencer to read array with no pulse. A set-up code of F0h is one such cycle.
- R11: While lockout is high, write cycles have no effect, and the sequence and auto_sel return to their idle values.
- R12: While pec_busy is high, every write except B0h is ignored, and a partially entered sequence is kept.
- R13: B0h is taken only while pec_busy is high and an erase started by this block has not finished. The erase is finished once pec_busy falls while not suspended. Taking B0h gives go_susp and sets suspended. While suspended, a program sequence is accepted, but an 80h or 60h set-up aborts. Data 30h as a single cycle with pec_busy low, in idle while suspended, gives go_resume and clears suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lockout | input | 1 | Low-supply lockout, returns to read array |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Bus address |
| data | input | DW | Bus data |
| pec_busy | input | 1 | Program/erase controller is running |
| go_prog | output | 1 | Start program pulse |
| go_berase | output | 1 | Start block erase pulse |
| go_cerase | output | 1 | Start chip erase pulse |
| go_prot | output | 1 | Start block protect pulse |
| go_unprot | output | 1 | Start blocks unprotect pulse |
| go_susp | output | 1 | Suspend erase pulse |
| go_resume | output | 1 | Resume erase pulse |
| op_addr | output | AW | Address for the started operation |
| op_data | output | DW | Data for the started operation |
| auto_sel | output | 1 | Auto select mode active |
| suspended | output | 1 | An erase is suspended |

## Verification
A sequence position held wrongly is invisible until the cycle that completes a command. It then shows as a missing pulse, an extra pulse or the wrong pulse on the commit clock, one cycle after the strobes rise. A stale erase-running flag shows only when a later B0h is accepted or refused. Each scenario therefore finishes with a write whose pulse, or lack of pulse, exposes the hidden state, sampled on the cycle after that write ends.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lockout,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          pec_busy,
  output logic          go_prog,
  output logic          go_berase,
  output logic          go_cerase,
  output logic          go_prot,
  output logic          go_unprot,
  output logic          go_susp,
  output logic          go_resume,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          auto_sel,
  output logic          suspended
);
  localparam int UW = 11;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_SETUP, S_PROG, S_X1, S_X2, S_CONF} st_t;

  st_t           st;
  logic          xprot, wr_q, busy_q, erase_run;
  logic [AW-1:0] a_lat;
  logic [DW-1:0] d_lat;

  wire       wr_act    = !ce_n && !we_n && oe_n;
  wire       commit    = wr_q && !wr_act && !lockout;
  wire [7:0] cmd       = d_lat[7:0];
  wire       unl1      = cmd == 8'hAA && a_lat[UW-1:0] == 11'h555;
  wire       unl2      = cmd == 8'h55 && a_lat[UW-1:0] == 11'h2AA;
  wire       take_susp = commit && cmd == 8'hB0 && pec_busy && erase_run && !suspended;
  wire       take_res  = commit && cmd == 8'h30 && !pec_busy && suspended && st == S_IDLE;
  wire       step      = commit && !pec_busy && !take_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      xprot <= 1'b0;
      wr_q <= 1'b0;
      busy_q <= 1'b0;
      erase_run <= 1'b0;
      a_lat <= '0;
      d_lat <= '0;
      op_addr <= '0;
      op_data <= '0;
      auto_sel <= 1'b0;
      suspended <= 1'b0;
      {go_prog, go_berase, go_cerase, go_prot, go_unprot, go_susp, go_resume} <= '0;
    end else begin
      {go_prog, go_berase, go_cerase, go_prot, go_unprot, go_susp, go_resume} <= '0;
      wr_q <= wr_act;
      busy_q <= pec_busy;
      if (wr_act && !wr_q) a_lat <= addr;
      if (wr_act) d_lat <= data;
      if (busy_q && !pec_busy && !suspended) erase_run <= 1'b0;

      if (lockout) begin
        st <= S_IDLE;
        auto_sel <= 1'b0;
      end else if (take_susp) begin
        go_susp <= 1'b1;
        suspended <= 1'b1;
      end else if (take_res) begin
        go_resume <= 1'b1;
        suspended <= 1'b0;
      end else if (step) begin
        auto_sel <= 1'b0;
        st <= S_IDLE;
        case (st)
          S_IDLE:  if (unl1) st <= S_U1;
          S_U1:    if (unl2) st <= S_SETUP;
          S_SETUP:
            case (cmd)
              8'hA0: st <= S_PROG;
              8'h90: auto_sel <= 1'b1;
              8'h80: if (!suspended) begin st <= S_X1; xprot <= 1'b0; end
              8'h60: if (!suspended) begin st <= S_X1; xprot <= 1'b1; end
              default: ;
            endcase
          S_PROG: begin
            go_prog <= 1'b1;
            op_addr <= a_lat;
            op_data <= d_lat;
          end
          S_X1:    if (unl1) st <= S_X2;
          S_X2:    if (unl2) st <= S_CONF;
          S_CONF: begin
            op_addr <= a_lat;
            op_data <= d_lat;
            if (!xprot && cmd == 8'h30) begin go_berase <= 1'b1; erase_run <= 1'b1; end
            if (!xprot && cmd == 8'h10) begin go_cerase <= 1'b1; erase_run <= 1'b1; end
            if (xprot && cmd == 8'h40) go_prot <= 1'b1;
            if (xprot && cmd == 8'h20) go_unprot <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic lockout,
  input logic pec_busy,
  input logic go_prog,
  input logic go_berase,
  input logic go_cerase,
  input logic go_prot,
  input logic go_unprot,
  input logic go_susp,
  input logic go_resume,
  input logic auto_sel,
  input logic suspended
);
  wire [6:0] pv = {go_prog, go_berase, go_cerase, go_prot, go_unprot, go_susp, go_resume};

  assert_one_start_R5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pv));

  assert_prog_single_R5: assert property (@(posedge clk) disable iff (!rst_n) go_prog |=> !go_prog);

  assert_no_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prog | go_berase | go_cerase | go_prot | go_unprot | go_resume) |-> !$past(pec_busy));

  assert_susp_needs_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    go_susp |-> $past(pec_busy) && suspended);

  assert_susp_rise_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> go_susp);

  assert_resume_R13: assert property (@(posedge clk) disable iff (!rst_n)
    go_resume |-> $past(suspended) && !suspended);

  assert_lockout_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> !auto_sel && pv == 7'd0);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lockout(lockout), .pec_busy(pec_busy),
  .go_prog(go_prog), .go_berase(go_berase), .go_cerase(go_cerase),
  .go_prot(go_prot), .go_unprot(go_unprot), .go_susp(go_susp),
  .go_resume(go_resume), .auto_sel(auto_sel), .suspended(suspended)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [6:0] P_NONE = 7'b0000000, P_PROG = 7'b1000000, P_BE = 7'b0100000,
    P_CE = 7'b0010000, P_PR = 7'b0001000, P_UP = 7'b0000100, P_SU = 7'b0000010,
    P_RE = 7'b0000001;

  logic clk = 1'b0, rst_n = 1'b0, lockout = 1'b0, pec_busy = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic go_prog, go_berase, go_cerase, go_prot, go_unprot, go_susp, go_resume;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic auto_sel, suspended;
  int n_chk = 0, n_bad = 0;

  wire [6:0] pv = {go_prog, go_berase, go_cerase, go_prot, go_unprot, go_susp, go_resume};

  always #4 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lockout(lockout), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data(data), .pec_busy(pec_busy),
    .go_prog(go_prog), .go_berase(go_berase), .go_cerase(go_cerase), .go_prot(go_prot),
    .go_unprot(go_unprot), .go_susp(go_susp), .go_resume(go_resume),
    .op_addr(op_addr), .op_data(op_data), .auto_sel(auto_sel), .suspended(suspended)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_oe(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe);
    @(negedge clk);
    addr = a; data = d; oe_n = oe; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_oe(a, d, 1'b1);
  endtask

  task automatic unlock;
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
  endtask

  task automatic t_reset;
    chk("R1 pulses", pv, P_NONE);
    chk("R1 auto_sel", auto_sel, 0);
    chk("R1 suspended", suspended, 0);
  endtask

  task automatic t_prog;
    unlock();
    chk("R4 no pulse on unlock", pv, P_NONE);
    wr(16'h0555, 16'h00A0);
    wr(16'h1234, 16'hBEEF);
    chk("R5 prog pulse", pv, P_PROG);
    chk("R5 op_addr", op_addr, 16'h1234);
    chk("R5 op_data", op_data, 16'hBEEF);
    @(negedge clk);
    chk("R5 pulse one cycle", pv, P_NONE);
  endtask

  task automatic t_berase;
    wr(16'hF555, 16'hFFAA);
    wr(16'h82AA, 16'h0055);
    wr(16'h0555, 16'h0080);
    unlock();
    wr(16'h4000, 16'h0030);
    chk("R6 block erase pulse, R4 upper bits ignored", pv, P_BE);
    chk("R6 op_addr", op_addr, 16'h4000);
    pec_busy = 1'b1; repeat (3) @(negedge clk); pec_busy = 1'b0; @(negedge clk);
  endtask

  task automatic t_cerase;
    unlock(); wr(16'h0555, 16'h0080); unlock();
    wr(16'h0555, 16'h0010);
    chk("R7 chip erase pulse", pv, P_CE);
    pec_busy = 1'b1; repeat (3) @(negedge clk); pec_busy = 1'b0; @(negedge clk);
  endtask

  task automatic t_protect;
    unlock(); wr(16'h0555, 16'h0060); unlock();
    wr(16'h2000, 16'h0040);
    chk("R8 protect pulse", pv, P_PR);
    chk("R8 protect op_addr", op_addr, 16'h2000);
    unlock(); wr(16'h0555, 16'h0060); unlock();
    wr(16'h0000, 16'h0020);
    chk("R8 unprotect pulse", pv, P_UP);
  endtask

  task automatic t_autosel;
    unlock(); wr(16'h0555, 16'h0090);
    chk("R9 auto_sel set", auto_sel, 1);
    chk("R9 no pulse", pv, P_NONE);
    wr(16'h0000, 16'h00F0);
    chk("R9 auto_sel cleared", auto_sel, 0);
  endtask

  task automatic t_abort;
    wr(16'h0555, 16'h00AA); wr(16'h0123, 16'h0055);
    wr(16'h0555, 16'h00A0); wr(16'h1000, 16'h1111);
    chk("R10 bad unlock address aborts", pv, P_NONE);
    unlock(); wr(16'h0555, 16'h0080);
    wr(16'h0555, 16'h00AA); wr(16'h02AB, 16'h0055);
    wr(16'h4000, 16'h0030);
    chk("R10 bad second unlock aborts erase", pv, P_NONE);
    unlock(); wr(16'h0555, 16'h00F0);
    wr(16'h1234, 16'h5678);
    chk("R10 F0h setup returns to read array", pv, P_NONE);
  endtask

  task automatic t_latch;
    unlock(); wr(16'h0555, 16'h00A0);
    @(negedge clk); addr = 16'h0100; data = 16'h0001; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); addr = 16'h0F00; data = 16'h1111;
    @(negedge clk); data = 16'h2222;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    chk("R3 pulse on first rise", pv, P_PROG);
    chk("R3 address at write start", op_addr, 16'h0100);
    chk("R3 data at write end", op_data, 16'h2222);
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_oe;
    unlock(); wr(16'h0555, 16'h00A0);
    wr_oe(16'h0300, 16'h9999, 1'b0);
    chk("R2 oe_n low is no write", pv, P_NONE);
    wr(16'h0200, 16'h3333);
    chk("R2 sequence kept", pv, P_PROG);
    chk("R2 data of real write", op_data, 16'h3333);
  endtask

  task automatic t_lockout;
    unlock(); wr(16'h0555, 16'h0090);
    @(negedge clk); lockout = 1'b1;
    @(negedge clk); lockout = 1'b0;
    chk("R11 lockout clears auto_sel", auto_sel, 0);
    unlock(); wr(16'h0555, 16'h00A0);
    @(negedge clk); lockout = 1'b1;
    wr(16'h0700, 16'h7777);
    chk("R11 write ignored in lockout", pv, P_NONE);
    lockout = 1'b0;
    wr(16'h0701, 16'h7778);
    chk("R11 sequence reset by lockout", pv, P_NONE);
  endtask

  task automatic t_busy;
    pec_busy = 1'b1;
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h0300, 16'h4444);
    chk("R12 program ignored while busy", pv, P_NONE);
    pec_busy = 1'b0;
    wr(16'h0301, 16'h4445);
    chk("R12 nothing pending after busy", pv, P_NONE);
    unlock();
    pec_busy = 1'b1;
    wr(16'h0555, 16'h00F0);
    pec_busy = 1'b0;
    wr(16'h0555, 16'h00A0); wr(16'h0500, 16'h5555);
    chk("R12 partial sequence kept", pv, P_PROG);
    chk("R12 op_data", op_data, 16'h5555);
  endtask

  task automatic t_suspend;
    pec_busy = 1'b1;
    wr(16'h0000, 16'h00B0);
    chk("R13 suspend refused without erase", pv, P_NONE);
    chk("R13 suspended stays 0", suspended, 0);
    pec_busy = 1'b0;
    unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'h4000, 16'h0030);
    chk("R13 erase start", pv, P_BE);
    pec_busy = 1'b1;
    wr(16'h0000, 16'h00B0);
    chk("R13 suspend pulse", pv, P_SU);
    chk("R13 suspended set", suspended, 1);
    pec_busy = 1'b0;
    unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'h6000, 16'h0030);
    chk("R13 erase refused while suspended", pv, P_NONE);
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h6000, 16'h6666);
    chk("R13 program while suspended", pv, P_PROG);
    pec_busy = 1'b1;
    wr(16'h0000, 16'h0030);
    chk("R13 resume ignored while busy", pv, P_NONE);
    pec_busy = 1'b0;
    wr(16'h0000, 16'h0030);
    chk("R13 resume pulse", pv, P_RE);
    chk("R13 suspended cleared", suspended, 0);
    pec_busy = 1'b1; repeat (3) @(negedge clk); pec_busy = 1'b0; @(negedge clk);
    pec_busy = 1'b1;
    wr(16'h0000, 16'h00B0);
    chk("R13 suspend refused after erase ends", pv, P_NONE);
    pec_busy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_prog();
    t_berase();
    t_cerase();
    t_protect();
    t_autosel();
    t_abort();
    t_latch();
    t_oe();
    t_lockout();
    t_busy();
    t_suspend();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule